// File: doc/BRIEF.md
# Toggle-Handshake Event Synchronizer

This block carries single events, each with a data word, from a source clock domain into an unrelated destination clock domain. The source side does not send a pulse and wait for it to be released. It inverts a request level once for each event. The destination detects that level change and issues a one-cycle output pulse with the word. It then inverts an acknowledge level that travels back to the source. Both level changes are found by comparing a synchronized level with a registered copy of its value from the previous cycle.

Every transfer is a single exchange: one request flip followed by one acknowledge flip. No return-to-idle phases are needed, so the round trip is about half as long as a four-phase level handshake. While a transfer is in flight, the source reports busy and holds the data word steady. An event that arrives while the source is busy is refused and flagged in the same cycle. The block has no queue.

Top module: `hhs_top`

## Requirements
- R1: After reset, src_busy, src_reject and dst_pulse are all 0, and dst_data is 0.
- R2: When src_event is 1 at a source clock edge and src_busy is 0, the event is accepted, and src_busy reads 1 from that edge onward.
- R3: While src_busy is 1, src_reject equals src_event in the same cycle. A rejected event starts no transfer and never yields a destination pulse.
- R4: Each accepted event yields exactly one dst_pulse, one destination cycle wide. Pulses occur in the order the events were accepted.
- R5: In the cycle dst_pulse is 1, dst_data equals the src_data value present when the event was accepted, even if src_data changes while the transfer is in flight.
- R6: src_busy falls only after the destination pulse for the outstanding transfer has been issued. It falls within 40 source cycles of acceptance when the destination clock period is at most 22 ns.
- R7: Both directions of the request level (0 to 1 and 1 to 0) signal a transfer, so back-to-back transfers all complete.
- R8: Transfers complete correctly when the destination clock is equal to, faster than or slower than the source clock.
- R9: When dst_pulse is 0, dst_data keeps the word of the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_event | input | 1 | Event request, sampled on src_clk |
| src_data | input | DATA_W | Word sent along with the event |
| src_busy | output | 1 | A transfer is in flight; new events are refused |
| src_reject | output | 1 | An event arrived while busy and was dropped |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous |
| dst_pulse | output | 1 | One-cycle pulse per delivered event |
| dst_data | output | DATA_W | Word of the latest delivered event |

## Verification
Most wrong internal states show up in how src_busy behaves or in how many destination pulses appear. A stale previous-value register on the destination side produces either a missing pulse or a doubled pulse; a doubled pulse is visible in the very next destination cycle. A lost acknowledge flip leaves src_busy stuck high, and the busy-length bound catches this within 40 source cycles. A data register that is not held while busy shows up as a word mismatch at the pulse that delivers it. Running the destination clock slower than, equal to and faster than the source clock exposes edge-detection faults that only appear for one clock ratio.

// File: rtl/hhs_pkg.sv
`timescale 1ns/1ps
package hhs_pkg;
  // A level change between two consecutive samples marks one transfer.
  function automatic logic toggled(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

  // Next value of a signalling level when a new phase is launched.
  function automatic logic flip(input logic v);
    return ~v;
  endfunction
endpackage

// File: rtl/hhs_sync.sv
`timescale 1ns/1ps
module hhs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/hhs_src.sv
`timescale 1ns/1ps
module hhs_src
  import hhs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic [DW-1:0] data,
  input  logic          ack_sync,
  output logic          busy,
  output logic          reject,
  output logic          req,
  output logic [DW-1:0] held,
  output logic          accept,
  output logic          ack_seen
);
  logic ack_prev;

  assign accept   = ev & ~busy;
  assign reject   = ev & busy;
  assign ack_seen = toggled(ack_sync, ack_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev <= 1'b0;
      req      <= 1'b0;
      busy     <= 1'b0;
      held     <= '0;
    end else begin
      ack_prev <= ack_sync;
      if (accept) begin
        req  <= flip(req);
        busy <= 1'b1;
        held <= data;
      end else if (ack_seen) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hhs_dst.sv
`timescale 1ns/1ps
module hhs_dst
  import hhs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_sync,
  input  logic [DW-1:0] src_word,
  output logic          pulse,
  output logic [DW-1:0] word,
  output logic          ack,
  output logic          req_seen
);
  logic req_prev;

  assign req_seen = toggled(req_sync, req_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev <= 1'b0;
      pulse    <= 1'b0;
      word     <= '0;
      ack      <= 1'b0;
    end else begin
      req_prev <= req_sync;
      pulse    <= req_seen;
      if (req_seen) begin
        word <= src_word;
        ack  <= flip(ack);
      end
    end
  end
endmodule

// File: rtl/hhs_top.sv
`timescale 1ns/1ps
module hhs_top #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_event,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_busy,
  output logic              src_reject,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_pulse,
  output logic [DATA_W-1:0] dst_data
);
  // Named internal events, visible to the bound checker.
  logic              req_lvl, ack_lvl;
  logic              req_in_dst, ack_in_src;
  logic              src_accept, ack_seen, req_seen;
  logic [DATA_W-1:0] held_word;

  hhs_src #(.DW(DATA_W)) u_src (
    .clk      (src_clk),
    .rst_n    (src_rst_n),
    .ev       (src_event),
    .data     (src_data),
    .ack_sync (ack_in_src),
    .busy     (src_busy),
    .reject   (src_reject),
    .req      (req_lvl),
    .held     (held_word),
    .accept   (src_accept),
    .ack_seen (ack_seen)
  );

  hhs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (dst_clk),
    .rst_n (dst_rst_n),
    .d     (req_lvl),
    .q     (req_in_dst)
  );

  hhs_dst #(.DW(DATA_W)) u_dst (
    .clk      (dst_clk),
    .rst_n    (dst_rst_n),
    .req_sync (req_in_dst),
    .src_word (held_word),
    .pulse    (dst_pulse),
    .word     (dst_data),
    .ack      (ack_lvl),
    .req_seen (req_seen)
  );

  hhs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (ack_lvl),
    .q     (ack_in_src)
  );
endmodule

// File: rtl/hhs_checker.sv
`timescale 1ns/1ps
module hhs_checker #(
  parameter int DW = 8
) (
  input logic          src_clk,
  input logic          src_rst_n,
  input logic          dst_clk,
  input logic          dst_rst_n,
  input logic          src_accept,
  input logic          src_reject,
  input logic          src_busy,
  input logic          ack_seen,
  input logic          req_lvl,
  input logic [DW-1:0] held_word,
  input logic          req_seen,
  input logic          dst_pulse
);
  assert_accept_busy_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_accept |=> src_busy);

  assert_reject_no_launch_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_reject |=> $stable(req_lvl));

  assert_busy_until_ack_R6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_busy && !ack_seen) |=> src_busy);

  assert_word_held_R5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_busy |=> $stable(held_word));

  assert_req_moves_on_accept_R7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !src_accept |=> $stable(req_lvl));

  assert_pulse_follows_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    req_seen |=> dst_pulse);

  assert_pulse_single_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_pulse |=> !dst_pulse);
endmodule

bind hhs_top hhs_checker #(.DW(DATA_W)) u_chk (
  .src_clk    (src_clk),
  .src_rst_n  (src_rst_n),
  .dst_clk    (dst_clk),
  .dst_rst_n  (dst_rst_n),
  .src_accept (src_accept),
  .src_reject (src_reject),
  .src_busy   (src_busy),
  .ack_seen   (ack_seen),
  .req_lvl    (req_lvl),
  .held_word  (held_word),
  .req_seen   (req_seen),
  .dst_pulse  (dst_pulse)
);

// File: tb/hhs_top_tb.sv
`timescale 1ns/1ps
module hhs_top_tb;
  localparam int DW       = 8;
  localparam int BUSY_MAX = 40;
  localparam int PHASE_N  = 1500;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic          src_event = 1'b0;
  logic [DW-1:0] src_data  = '0;
  logic          src_busy, src_reject, dst_pulse;
  logic [DW-1:0] dst_data;
  realtime       dst_half = 2.5;

  int            checks = 0;
  int            errors = 0;
  int            accepted = 0;
  int            pulses = 0;
  int            exp_q[$];
  logic [DW-1:0] last_word = '0;
  logic          prev_pulse = 1'b0;

  always #2.5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  hhs_top #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .src_clk(src_clk), .src_rst_n(rst_n), .src_event(src_event),
    .src_data(src_data), .src_busy(src_busy), .src_reject(src_reject),
    .dst_clk(dst_clk), .dst_rst_n(rst_n), .dst_pulse(dst_pulse),
    .dst_data(dst_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Destination side: pulses are popped in order and compared (R4, R5, R9).
  always @(negedge dst_clk) begin
    if (rst_n) begin
      if (dst_pulse) begin
        check(!prev_pulse, "R4", "pulse wider than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "pulse without accepted event", pulses + 1, accepted);
        end else begin
          int w;
          w = exp_q.pop_front();
          check(dst_data == w[DW-1:0], "R5", "delivered word", dst_data, w);
        end
        pulses++;
        last_word = dst_data;
      end else begin
        check(dst_data == last_word, "R9", "word held between pulses", dst_data, last_word);
      end
      prev_pulse = dst_pulse;
    end
  end

  initial begin : watchdog
    #500us;
    check(1'b0, "R6", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    realtime halves[4] = '{2.5, 11.0, 1.5, 7.0};
    logic pe, pb;
    logic [DW-1:0] pd;
    int busy_len;
    pe = 0; pb = 0; pd = '0; busy_len = 0;

    repeat (4) @(negedge src_clk);
    check(src_busy == 0 && src_reject == 0 && dst_pulse == 0 && dst_data == 0,
          "R1", "reset state", {src_busy, src_reject, dst_pulse}, 0);
    rst_n = 1'b1;
    @(negedge src_clk);
    check(src_busy == 0, "R1", "idle after reset", src_busy, 0);

    for (int p = 0; p < 4; p++) begin
      int start_acc;
      dst_half  = halves[p];
      start_acc = accepted;
      for (int c = 0; c < PHASE_N; c++) begin
        @(negedge src_clk);
        if (pe && !pb) begin
          check(src_busy == 1, "R2", "busy after accept", src_busy, 1);
          exp_q.push_back(int'(pd));
          accepted++;
        end
        if (pb && !src_busy) begin
          check(pulses == accepted, "R6", "busy fell before pulse", pulses, accepted);
          check(busy_len <= BUSY_MAX, "R6", "busy length", busy_len, BUSY_MAX);
        end
        if (src_busy) busy_len++;
        else          busy_len = 0;
        if (busy_len == BUSY_MAX + 1)
          check(1'b0, "R6", "busy stuck", busy_len, BUSY_MAX);
        src_event = (($urandom % 3) == 0);
        src_data  = DW'($urandom);
        #0.5;
        check(src_reject == (src_event && src_busy), "R3", "reject flag",
              src_reject, int'(src_event && src_busy));
        pe = src_event; pb = src_busy; pd = src_data;
      end
      // Drain this phase before the clock ratio changes.
      @(negedge src_clk);
      if (pe && !pb) begin exp_q.push_back(int'(pd)); accepted++; end
      src_event = 1'b0;
      pe = 0; pb = 0;
      for (int k = 0; k < 200 && (src_busy || exp_q.size() != 0); k++)
        @(negedge src_clk);
      busy_len = 0;
      check(pulses == accepted, "R3", "pulse count equals accepted count", pulses, accepted);
      check(accepted - start_acc >= 4, "R7", "back-to-back transfers in phase",
            accepted - start_acc, 4);
      check(exp_q.size() == 0 && !src_busy, "R8", "phase drained at clock ratio",
            exp_q.size(), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule